// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a small processor datapath built around seven general registers. Two operand multiplexers place a selected value on bus A and on bus B. An arithmetic and logic unit combines the two buses, and a destination decoder loads the unit's output into one register at the next clock edge. A microoperation such as "register 1 takes register 2 plus register 3" therefore completes in a single clock.

The whole microoperation comes from one packed control word. The word is presented directly on a port, together with a valid strobe. Select code 0 on either source field places an external input word on the bus instead of a register. On the destination field, code 0 means that nothing is written. The ALU output bus is driven to a port in every cycle, so a control word with no write can be used to read any register. A zero flag and a carry flag capture the properties of each valid result.

Top module: `regbus_datapath`

## Requirements
- R1: The 14-bit control word is split into fields: source A select in bits [13:11], source B select in bits [10:8], destination select in bits [7:5] and ALU function in bits [4:0].
- R2: Each source field acts on its own bus. Code 0 places `ext_in` on that bus, and codes 1 to 7 place the register with that number on it.
- R3: On a rising clock edge with `ctl_valid` high and a nonzero destination code, the register with that number takes the ALU result. No other register changes.
- R4: When `ctl_valid` is low or the destination code is 0, no register changes at the clock edge.
- R5: `result_out` is driven combinationally from the present control word, `ext_in` and the register contents in every cycle, whatever the state of `ctl_valid`.
- R6: The arithmetic function codes are: 0 passes A, 1 gives A+1, 2 gives A+B, 3 gives A-B and 4 gives A-1. All results are taken modulo 256.
- R7: The logic and shift function codes are: 5 gives A AND B, 6 gives A OR B, 7 gives A XOR B and 8 gives NOT A. Code 9 shifts A right by one and fills a zero into the top bit. Code 10 shifts A left by one and fills a zero into bit 0.
- R8: Function codes 11 to 31 give a result of 0 and a carry of 0.
- R9: The carry flag is set as follows. For add and increment it is the carry out. For subtract it is 1 when A >= B, and for decrement it is 1 when A is nonzero. For shift right it is the bit shifted out of bit 0, and for shift left it is the bit shifted out of bit 7. For every other code it is 0.
- R10: `zero_flag` and `carry_flag` are registered from the result at each clock edge with `ctl_valid` high. They hold their values when `ctl_valid` is low.
- R11: Reset (`rst_n` low) clears all seven registers and both flags to zero.
- R12: When one register is both a source and the destination, the operation uses the value it held before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_valid | input | 1 | Control word is valid this cycle |
| ctl_word | input | 14 | Packed microoperation: source A, source B, destination, function |
| ext_in | input | 8 | External word selected by source code 0 |
| result_out | output | 8 | ALU output bus |
| zero_flag | output | 1 | Registered: last valid result was zero |
| carry_flag | output | 1 | Registered: carry of last valid result |

## Verification
The table first loads registers from the external word. It then chains operations so that each result relies on values written earlier. This exposes a wrong destination decode or a swapped source field, because a later read returns the wrong register. Operand pairs are chosen to show the carry cases apart: an add that wraps to zero, subtracts with the larger operand on each side, and a decrement of one against a decrement of zero. Shifts use operands with differing end bits. A self-targeted add checks the read-before-write order. Writes with the strobe low, writes to code 0 and unused function codes are each followed by a readback that shows the register left untouched or cleared as required.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

    localparam int OPR_W = 5;

    typedef enum logic [OPR_W-1:0] {
        OP_PASS = 5'd0,
        OP_INC  = 5'd1,
        OP_ADD  = 5'd2,
        OP_SUB  = 5'd3,
        OP_DEC  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_NOT  = 5'd8,
        OP_SHR  = 5'd9,
        OP_SHL  = 5'd10
    } alu_op_e;

    typedef struct packed {
        logic zero;
        logic carry;
    } flags_t;

endpackage

// File: rtl/rbd_fields.sv
module rbd_fields #(
    parameter int SEL_W = 3,
    parameter int OPR_W = rbd_pkg::OPR_W,
    localparam int CTL_W = 3 * SEL_W + OPR_W
) (
    input  logic [CTL_W-1:0] ctl_word,
    output logic [SEL_W-1:0] sela,
    output logic [SEL_W-1:0] selb,
    output logic [SEL_W-1:0] seld,
    output logic [OPR_W-1:0] opr
);
    localparam int SELD_LO = OPR_W;
    localparam int SELB_LO = OPR_W + SEL_W;
    localparam int SELA_LO = OPR_W + 2 * SEL_W;

    // R1: field positions within the packed control word
    assign sela = ctl_word[SELA_LO +: SEL_W];
    assign selb = ctl_word[SELB_LO +: SEL_W];
    assign seld = ctl_word[SELD_LO +: SEL_W];
    assign opr  = ctl_word[0 +: OPR_W];
endmodule

// File: rtl/rbd_regbank.sv
module rbd_regbank #(
    parameter int WIDTH = 8,
    parameter int SEL_W = 3,
    localparam int NREG = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] wsel,
    input  logic [WIDTH-1:0] wdata,
    input  logic [SEL_W-1:0] asel,
    input  logic [SEL_W-1:0] bsel,
    input  logic [WIDTH-1:0] ext_in,
    output logic [WIDTH-1:0] a_bus,
    output logic [WIDTH-1:0] b_bus
);
    logic [NREG:1][WIDTH-1:0] regs_d, regs_q;
    logic [NREG:1]            hit;
    logic [NREG:0][WIDTH-1:0] rd_view;

    // Destination decoder: one enable per register (R3, R4)
    for (genvar k = 1; k <= NREG; k++) begin : g_dec
        assign hit[k] = we && (wsel == SEL_W'(k));
    end

    always_comb begin
        regs_d = regs_q;
        for (int k = 1; k <= NREG; k++) begin
            if (hit[k]) begin
                regs_d[k] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // Entry 0 of the read view is the external word (R2)
    assign rd_view = {regs_q, ext_in};
    assign a_bus   = rd_view[asel];
    assign b_bus   = rd_view[bsel];
endmodule

// File: rtl/rbd_alu.sv
module rbd_alu #(
    parameter int WIDTH = 8,
    parameter int OPR_W = rbd_pkg::OPR_W
) (
    input  logic [OPR_W-1:0] op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res,
    output logic             carry
);
    import rbd_pkg::*;

    logic [WIDTH:0] ext_sum;

    always_comb begin
        ext_sum = '0;
        res     = '0;
        carry   = 1'b0;
        case (op)
            OP_PASS: res = a;
            OP_INC: begin
                ext_sum = {1'b0, a} + (WIDTH+1)'(1);
                {carry, res} = ext_sum;
            end
            OP_ADD: begin
                ext_sum = {1'b0, a} + {1'b0, b};
                {carry, res} = ext_sum;
            end
            OP_SUB: begin
                ext_sum = {1'b0, a} + {1'b0, ~b} + (WIDTH+1)'(1);
                {carry, res} = ext_sum;
            end
            OP_DEC: begin
                ext_sum = {1'b0, a} + {1'b0, {WIDTH{1'b1}}};
                {carry, res} = ext_sum;
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_NOT: res = ~a;
            OP_SHR: begin
                res   = {1'b0, a[WIDTH-1:1]};
                carry = a[0];
            end
            OP_SHL: begin
                res   = {a[WIDTH-2:0], 1'b0};
                carry = a[WIDTH-1];
            end
            default: begin
                res   = '0;
                carry = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/regbus_datapath.sv
module regbus_datapath #(
    parameter int WIDTH = 8,
    parameter int SEL_W = 3,
    localparam int OPR_W = rbd_pkg::OPR_W,
    localparam int CTL_W = 3 * SEL_W + OPR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_valid,
    input  logic [CTL_W-1:0] ctl_word,
    input  logic [WIDTH-1:0] ext_in,
    output logic [WIDTH-1:0] result_out,
    output logic             zero_flag,
    output logic             carry_flag
);
    import rbd_pkg::*;

    logic [SEL_W-1:0] sela, selb, seld;
    logic [OPR_W-1:0] opr;
    logic [WIDTH-1:0] a_bus, b_bus, alu_res;
    logic             alu_carry;
    logic             wr_en;
    flags_t           flags_d, flags_q;

    rbd_fields #(.SEL_W(SEL_W), .OPR_W(OPR_W)) u_fields (
        .ctl_word (ctl_word),
        .sela     (sela),
        .selb     (selb),
        .seld     (seld),
        .opr      (opr)
    );

    assign wr_en = ctl_valid && (seld != '0);

    rbd_regbank #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en),
        .wsel   (seld),
        .wdata  (alu_res),
        .asel   (sela),
        .bsel   (selb),
        .ext_in (ext_in),
        .a_bus  (a_bus),
        .b_bus  (b_bus)
    );

    rbd_alu #(.WIDTH(WIDTH), .OPR_W(OPR_W)) u_alu (
        .op    (opr),
        .a     (a_bus),
        .b     (b_bus),
        .res   (alu_res),
        .carry (alu_carry)
    );

    always_comb begin
        flags_d = flags_q;
        if (ctl_valid) begin
            flags_d.zero  = (alu_res == '0);
            flags_d.carry = alu_carry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign result_out = alu_res;
    assign zero_flag  = flags_q.zero;
    assign carry_flag = flags_q.carry;
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
    parameter int WIDTH = 8,
    parameter int SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_valid,
    input logic [SEL_W-1:0] sela,
    input logic [SEL_W-1:0] seld,
    input logic [WIDTH-1:0] a_bus,
    input logic [WIDTH-1:0] ext_in,
    input logic [WIDTH-1:0] result_out,
    input logic             zero_flag,
    input logic             carry_flag
);
    assert_ext_on_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sela == '0) |-> (a_bus == ext_in));

    assert_writeback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctl_valid && (seld != '0)) && (sela == $past(seld)))
        |-> (a_bus == $past(result_out)));

    assert_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ctl_valid || (seld == '0)) &&
         (sela == $past(sela)) && (sela != '0))
        |-> (a_bus == $past(a_bus)));

    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ctl_valid))
        |-> ($stable(zero_flag) && $stable(carry_flag)));

    assert_zero_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctl_valid))
        |-> (zero_flag == ($past(result_out) == '0)));
endmodule

bind regbus_datapath rbd_checker #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_valid  (ctl_valid),
    .sela       (sela),
    .seld       (seld),
    .a_bus      (a_bus),
    .ext_in     (ext_in),
    .result_out (result_out),
    .zero_flag  (zero_flag),
    .carry_flag (carry_flag)
);

// File: tb/regbus_datapath_test.sv
module regbus_datapath_test;
    localparam int HALF = 10;   // 50 MHz
    localparam int NV   = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_valid = 1'b0;
    logic [13:0] ctl_word = '0;
    logic [7:0]  ext_in = '0;
    logic [7:0]  result_out;
    logic        zero_flag, carry_flag;

    int n_cmp = 0;
    int n_bad = 0;

    always #HALF clk = ~clk;

    regbus_datapath uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_valid  (ctl_valid),
        .ctl_word   (ctl_word),
        .ext_in     (ext_in),
        .result_out (result_out),
        .zero_flag  (zero_flag),
        .carry_flag (carry_flag)
    );

    // {srcA, srcB, dest, func, ext, result, zero, carry}
    localparam logic [31:0] VEC [NV] = '{
        {3'd0,3'd0,3'd1,5'd0 , 8'h3C, 8'h3C, 1'b0,1'b0},
        {3'd0,3'd0,3'd2,5'd0 , 8'hC5, 8'hC5, 1'b0,1'b0},
        {3'd0,3'd0,3'd3,5'd0 , 8'h01, 8'h01, 1'b0,1'b0},
        {3'd0,3'd0,3'd4,5'd0 , 8'hFF, 8'hFF, 1'b0,1'b0},
        {3'd2,3'd3,3'd5,5'd2 , 8'h00, 8'hC6, 1'b0,1'b0},
        {3'd4,3'd3,3'd6,5'd2 , 8'h00, 8'h00, 1'b1,1'b1},
        {3'd1,3'd2,3'd7,5'd3 , 8'h00, 8'h77, 1'b0,1'b0},
        {3'd2,3'd1,3'd7,5'd3 , 8'h00, 8'h89, 1'b0,1'b1},
        {3'd7,3'd0,3'd0,5'd0 , 8'h00, 8'h89, 1'b0,1'b0},
        {3'd4,3'd0,3'd6,5'd1 , 8'h00, 8'h00, 1'b1,1'b1},
        {3'd3,3'd0,3'd6,5'd4 , 8'h00, 8'h00, 1'b1,1'b1},
        {3'd6,3'd0,3'd6,5'd4 , 8'h00, 8'hFF, 1'b0,1'b0},
        {3'd2,3'd1,3'd0,5'd5 , 8'h00, 8'h04, 1'b0,1'b0},
        {3'd2,3'd1,3'd0,5'd6 , 8'h00, 8'hFD, 1'b0,1'b0},
        {3'd2,3'd1,3'd0,5'd7 , 8'h00, 8'hF9, 1'b0,1'b0},
        {3'd1,3'd0,3'd0,5'd8 , 8'h00, 8'hC3, 1'b0,1'b0},
        {3'd2,3'd0,3'd0,5'd9 , 8'h00, 8'h62, 1'b0,1'b1},
        {3'd2,3'd0,3'd0,5'd10, 8'h00, 8'h8A, 1'b0,1'b1},
        {3'd1,3'd0,3'd0,5'd10, 8'h00, 8'h78, 1'b0,1'b0},
        {3'd5,3'd5,3'd5,5'd7 , 8'h00, 8'h00, 1'b1,1'b0},
        {3'd5,3'd0,3'd0,5'd0 , 8'h00, 8'h00, 1'b1,1'b0},
        {3'd1,3'd1,3'd1,5'd2 , 8'h00, 8'h78, 1'b0,1'b0},
        {3'd1,3'd0,3'd0,5'd0 , 8'h00, 8'h78, 1'b0,1'b0},
        {3'd1,3'd2,3'd3,5'd11, 8'h00, 8'h00, 1'b1,1'b0},
        {3'd3,3'd0,3'd0,5'd0 , 8'h00, 8'h00, 1'b1,1'b0},
        {3'd0,3'd2,3'd0,5'd2 , 8'h3B, 8'h00, 1'b1,1'b1},
        {3'd4,3'd4,3'd0,5'd3 , 8'h00, 8'h00, 1'b1,1'b1},
        {3'd1,3'd0,3'd0,5'd2 , 8'h08, 8'h80, 1'b0,1'b0},
        {3'd6,3'd0,3'd0,5'd0 , 8'h00, 8'hFF, 1'b0,1'b0},
        {3'd0,3'd0,3'd0,5'd31, 8'hAA, 8'h00, 1'b1,1'b0},
        {3'd4,3'd0,3'd0,5'd9 , 8'h00, 8'h7F, 1'b0,1'b1}
    };

    localparam string TAG [NV] = '{
        "R1","R3","R3","R3","R6","R9","R9","R6","R4","R9","R6","R9","R7",
        "R7","R7","R7","R7","R7","R9","R10","R3","R12","R12","R8","R8",
        "R2","R9","R2","R4","R8","R7"
    };

    task automatic check(input string tag, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Drive at falling edge, check bus mid-low-phase, flags after the rising edge
    task automatic apply(input logic v, input logic [13:0] cw, input logic [7:0] ex,
                         input logic [7:0] exp_r, input logic exp_z, input logic exp_c,
                         input string tag, input bit chk_flags);
        @(negedge clk);
        ctl_valid = v;
        ctl_word  = cw;
        ext_in    = ex;
        #(HALF/2);
        check(tag, "result_out", int'(result_out), int'(exp_r));
        @(posedge clk);
        #(HALF/2);
        if (chk_flags) begin
            check(tag, "flags", int'({zero_flag, carry_flag}), int'({exp_z, exp_c}));
        end
    endtask

    initial begin
        #(2 * HALF * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #(HALF/2);
        // R11: flags and registers cleared by reset
        check("R11", "flags after reset", int'({zero_flag, carry_flag}), 0);
        for (int k = 1; k <= 7; k++) begin
            apply(1'b0, {3'(k), 3'd0, 3'd0, 5'd0}, 8'hEE, 8'h00, 1'b0, 1'b0, "R11", 1'b1);
        end
        // R5 bus driven with strobe low; R4 write suppressed; R10 flags held
        apply(1'b0, {3'd0, 3'd0, 3'd1, 5'd0}, 8'h55, 8'h55, 1'b0, 1'b0, "R5", 1'b1);
        apply(1'b0, {3'd1, 3'd0, 3'd0, 5'd0}, 8'h00, 8'h00, 1'b0, 1'b0, "R4", 1'b1);

        for (int i = 0; i < NV; i++) begin
            apply(1'b1, VEC[i][31:18], VEC[i][17:10], VEC[i][9:2],
                  VEC[i][1], VEC[i][0], TAG[i], 1'b1);
        end

        // R10: set both flags, then an invalid word must leave them set
        apply(1'b1, {3'd0, 3'd0, 3'd0, 5'd2}, 8'h80, 8'h00, 1'b1, 1'b1, "R9", 1'b1);
        apply(1'b0, {3'd0, 3'd0, 3'd1, 5'd0}, 8'h12, 8'h12, 1'b1, 1'b1, "R10", 1'b1);
        apply(1'b1, {3'd1, 3'd0, 3'd0, 5'd0}, 8'h00, 8'h78, 1'b0, 1'b0, "R4", 1'b1);

        // R11: mid-run reset clears a loaded register and the flags
        apply(1'b1, {3'd0, 3'd0, 3'd0, 5'd2}, 8'h80, 8'h00, 1'b1, 1'b1, "R9", 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        ctl_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #(HALF/2);
        check("R11", "flags after second reset", int'({zero_flag, carry_flag}), 0);
        apply(1'b0, {3'd2, 3'd0, 3'd0, 5'd0}, 8'h00, 8'h00, 1'b0, 1'b0, "R11", 1'b1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule